// File: doc/BRIEF.md
# Oversampled Serial Transmitter with Shortened Final Stop Bit

This block serialises bytes onto an asynchronous line that idles high. An external oversample clock enable paces it. Each bit lasts a fixed number of enabled ticks, set by a two-bit rate selector (8, 16 or 32 ticks per bit). A four-bit fraction code can shorten the final stop bit of each character. The meaning of that code depends on the selected rate. When two stop bits are chosen, only the second one is shortened. Codes that are not legal for the selected rate fall back to a full-length stop bit and raise a configuration error output.

The block watches a clear-to-send input while a character is on the line. If clear-to-send drops during a character, the character still completes. The transmitter then parks in a halted state: it raises a sticky lost flag, drives an interrupt unless that interrupt is masked, and holds its ready output low, so a pending byte stays with the producer. The transmitter leaves the halted state only in a cycle where the restart input and clear-to-send are both high. In flow-control mode, a drop of clear-to-send only pauses the transmitter between characters and raises no flag.

Top module: `uart_frac_tx`

## Requirements
- R1: After reset, txd is 1, cts_lost and irq are 0, and tx_ready equals cts. Whenever no character is being sent, txd is 1.
- R2: A byte is taken on a clock edge where tx_valid and tx_ready are both 1. The next cycle, txd drives the start bit (0). Then come the data bits LSB first, then the stop bit(s) (1). Each non-final bit lasts R enabled os_tick cycles. R is 8, 16 or 32 for cfg_os_mode 0, 1 or 2. The line state does not advance in cycles where os_tick is 0.
- R3: When cfg_os_mode is 1 and cfg_frac[3] is 1, the final stop bit lasts cfg_frac[2:0]+9 ticks. Code 15 gives 16 ticks and code 8 gives 9 ticks.
- R4: When cfg_os_mode is 2, every cfg_frac code is legal and the final stop bit lasts cfg_frac+17 ticks (17 to 32).
- R5: When cfg_os_mode is 0 and cfg_frac[3:2] is 2'b11, the final stop bit lasts cfg_frac[1:0]+5 ticks (5 to 8).
- R6: cfg_err is 1 exactly when the fraction code is illegal for the rate: mode 0 with cfg_frac below 12, mode 1 with cfg_frac below 8, or mode 3 (reserved, treated as 16 ticks per bit). An illegal setting gives a full-length final stop bit.
- R7: When cfg_two_stop is 1, the frame carries two stop bits. The first lasts the full R ticks and only the second is shortened.
- R8: With cfg_flow_ctl at 0, if cts is 0 in any cycle while a character is being sent, that character still completes. After it, cts_lost becomes 1, txd stays 1 and tx_ready stays 0, so a pending byte is not taken.
- R9: irq is 1 while cts_lost is 1 and cfg_irq_mask is 0, and it is 0 at all other times.
- R10: The halted state ends only on a clock edge where restart and cts are both 1. That edge clears cts_lost. A restart while cts is 0 has no effect.
- R11: With cfg_flow_ctl at 1, cts at 0 during a character never sets cts_lost. The transmitter returns to idle after the character, and tx_ready follows cts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversample clock enable |
| cfg_os_mode | input | 2 | Rate: 0=8x, 1=16x, 2=32x, 3=reserved |
| cfg_frac | input | 4 | Final stop bit fraction code |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_flow_ctl | input | 1 | 1 makes a cts drop a plain pause |
| cfg_irq_mask | input | 1 | 1 masks the interrupt |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Byte can be taken this cycle |
| cts | input | 1 | Clear to send, active high |
| restart | input | 1 | Restart command after a halt |
| txd | output | 1 | Serial line |
| cts_lost | output | 1 | Sticky halt-on-cts-loss flag |
| irq | output | 1 | Interrupt, unmasked cts_lost |
| cfg_err | output | 1 | Illegal fraction code for the rate |

## Verification
The checker takes the configuration inputs as stable from the acceptance of a byte until the halted or idle state is reached. The stimulus changes cfg_* only while the line is idle. The restart check also takes restart to be a short command and not a level held through a whole character. The bench pulses restart for single cycles inside the halted state. Clear-to-send may move at any cycle, and the bench drops and raises it both in the middle of characters and while idle.

// File: rtl/uft_pkg.sv
package uft_pkg;
   typedef enum logic [1:0] {
      OS_X8   = 2'd0,
      OS_X16  = 2'd1,
      OS_X32  = 2'd2,
      OS_RSVD = 2'd3
   } os_mode_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_HALT = 2'd2
   } tx_state_t;

   localparam int TICK_W = 6;
endpackage

// File: rtl/uft_stop_calc.sv
module uft_stop_calc
   import uft_pkg::*;
(
   input  logic [1:0]        mode,
   input  logic [3:0]        frac,
   output logic [TICK_W-1:0] bit_len,
   output logic [TICK_W-1:0] last_len,
   output logic              bad_code
);
   always_comb begin
      bit_len  = TICK_W'(16);
      last_len = TICK_W'(16);
      bad_code = 1'b0;
      case (os_mode_t'(mode))
         OS_X8: begin
            bit_len  = TICK_W'(8);
            bad_code = ~(frac[3] & frac[2]);
            last_len = bad_code ? TICK_W'(8) : TICK_W'(frac[1:0]) + TICK_W'(5);
         end
         OS_X16: begin
            bit_len  = TICK_W'(16);
            bad_code = ~frac[3];
            last_len = bad_code ? TICK_W'(16) : TICK_W'(frac[2:0]) + TICK_W'(9);
         end
         OS_X32: begin
            bit_len  = TICK_W'(32);
            last_len = TICK_W'(frac) + TICK_W'(17);
         end
         default: begin
            bad_code = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/uft_frame.sv
module uft_frame #(
   parameter int DATA_W  = 8,
   localparam int FRAME_W = DATA_W + 3
) (
   input  logic [DATA_W-1:0]  data,
   output logic [FRAME_W-1:0] frame
);
   assign frame[0] = 1'b0;
   for (genvar i = 0; i < DATA_W; i++) begin : g_data
      assign frame[i+1] = data[i];
   end
   assign frame[FRAME_W-1:FRAME_W-2] = 2'b11;
endmodule

// File: rtl/uft_engine.sv
module uft_engine
   import uft_pkg::*;
#(
   parameter int DATA_W  = 8,
   localparam int FRAME_W = DATA_W + 3,
   localparam int IDX_W   = $clog2(FRAME_W + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                os_tick,
   input  logic [FRAME_W-1:0]  frame,
   input  logic [TICK_W-1:0]   bit_len,
   input  logic [TICK_W-1:0]   last_len,
   input  logic                two_stop,
   input  logic                flow_ctl,
   input  logic                take,
   input  logic                cts,
   input  logic                restart,
   output tx_state_t           state,
   output logic                line,
   output logic                lost
);
   logic [FRAME_W-1:0] sh;
   logic [IDX_W-1:0]   idx, last_idx;
   logic [TICK_W-1:0]  tcnt, blen_q, llen_q, cur_len;
   logic               seen_q, at_last;

   assign at_last = (idx == last_idx);
   assign cur_len = at_last ? llen_q : blen_q;
   assign line    = (state == ST_SEND) ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sh       <= '1;
         idx      <= '0;
         last_idx <= '0;
         tcnt     <= '0;
         blen_q   <= '0;
         llen_q   <= '0;
         seen_q   <= 1'b0;
         lost     <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (take) begin
                  state    <= ST_SEND;
                  sh       <= frame;
                  idx      <= '0;
                  tcnt     <= '0;
                  blen_q   <= bit_len;
                  llen_q   <= last_len;
                  last_idx <= two_stop ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);
                  seen_q   <= 1'b0;
               end
            end
            ST_SEND: begin
               if (!cts) seen_q <= 1'b1;
               if (os_tick) begin
                  if (tcnt == cur_len - TICK_W'(1)) begin
                     tcnt <= '0;
                     sh   <= {1'b1, sh[FRAME_W-1:1]};
                     idx  <= idx + IDX_W'(1);
                     if (at_last) begin
                        if ((seen_q || !cts) && !flow_ctl) begin
                           state <= ST_HALT;
                           lost  <= 1'b1;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end
                  end else begin
                     tcnt <= tcnt + TICK_W'(1);
                  end
               end
            end
            ST_HALT: begin
               if (restart && cts) begin
                  state <= ST_IDLE;
                  lost  <= 1'b0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_frac_tx.sv
module uart_frac_tx
   import uft_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic [1:0]        cfg_os_mode,
   input  logic [3:0]        cfg_frac,
   input  logic              cfg_two_stop,
   input  logic              cfg_flow_ctl,
   input  logic              cfg_irq_mask,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic              cts,
   input  logic              restart,
   output logic              txd,
   output logic              cts_lost,
   output logic              irq,
   output logic              cfg_err
);
   localparam int FRAME_W = DATA_W + 3;

   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("uart_frac_tx: DATA_W must lie in 5..9");
   end

   logic [TICK_W-1:0]  bit_len, last_len;
   logic [FRAME_W-1:0] frame;
   tx_state_t          state;
   logic               take;

   uft_stop_calc u_calc (
      .mode     (cfg_os_mode),
      .frac     (cfg_frac),
      .bit_len  (bit_len),
      .last_len (last_len),
      .bad_code (cfg_err)
   );

   uft_frame #(.DATA_W(DATA_W)) u_frame (
      .data  (tx_data),
      .frame (frame)
   );

   assign tx_ready = (state == ST_IDLE) && cts;
   assign take     = tx_valid && tx_ready;

   uft_engine #(.DATA_W(DATA_W)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .os_tick  (os_tick),
      .frame    (frame),
      .bit_len  (bit_len),
      .last_len (last_len),
      .two_stop (cfg_two_stop),
      .flow_ctl (cfg_flow_ctl),
      .take     (take),
      .cts      (cts),
      .restart  (restart),
      .state    (state),
      .line     (txd),
      .lost     (cts_lost)
   );

   assign irq = cts_lost & ~cfg_irq_mask;
endmodule

// File: rtl/uft_chk.sv
module uft_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_valid,
   input logic tx_ready,
   input logic txd,
   input logic cts,
   input logic restart,
   input logic cts_lost,
   input logic cfg_flow_ctl
);
   // R1
   idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> txd);
   // R2
   start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !txd);
   // R8
   halt_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cts_lost |-> !tx_ready);
   // R8
   halt_line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cts_lost) |-> txd);
   // R10
   restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cts_lost) |-> $past(restart && cts));
   // R11
   flow_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cts_lost) |-> !$past(cfg_flow_ctl));
endmodule

bind uart_frac_tx uft_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tx_valid     (tx_valid),
   .tx_ready     (tx_ready),
   .txd          (txd),
   .cts          (cts),
   .restart      (restart),
   .cts_lost     (cts_lost),
   .cfg_flow_ctl (cfg_flow_ctl)
);

// File: tb/sim_uart_frac_tx.sv
`timescale 1ns/1ps
module sim_uart_frac_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick;
   logic [1:0] cfg_os_mode = 2'd1;
   logic [3:0] cfg_frac = 4'hF;
   logic       cfg_two_stop = 1'b0;
   logic       cfg_flow_ctl = 1'b0;
   logic       cfg_irq_mask = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_valid = 1'b0;
   logic       tx_ready;
   logic       cts = 1'b1;
   logic       restart = 1'b0;
   logic       txd, cts_lost, irq, cfg_err;

   int errors = 0;
   int checks = 0;
   bit rand_tick = 1'b0;
   bit done = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;

   uart_frac_tx u0 (.*);

   always @(negedge clk) begin
      lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      os_tick <= rand_tick ? lfsr[0] : 1'b1;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int rate_of(input int mode);
      if (mode == 0) return 8;
      if (mode == 2) return 32;
      return 16;
   endfunction

   function automatic bit illegal(input int mode, input int frac);
      return (mode == 3) || (mode == 0 && frac < 12) || (mode == 1 && frac < 8);
   endfunction

   function automatic int stop_of(input int mode, input int frac);
      if (illegal(mode, frac)) return rate_of(mode);
      if (mode == 0) return frac - 7;
      if (mode == 1) return frac + 1;
      return frac + 17;
   endfunction

   // behavioural reference model
   int m_state = 0;
   int m_cnt = 0;
   bit m_seen = 0;
   bit m_lost = 0;
   bit m_bits[$];
   int m_dur[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_lost = 0; m_cnt = 0;
         m_bits.delete(); m_dur.delete();
      end else begin
         case (m_state)
            0: if (tx_valid && cts) begin
               int r, s;
               r = rate_of(cfg_os_mode);
               s = stop_of(cfg_os_mode, cfg_frac);
               m_bits.delete(); m_dur.delete();
               m_bits.push_back(1'b0); m_dur.push_back(r);
               for (int i = 0; i < 8; i++) begin
                  m_bits.push_back(tx_data[i]); m_dur.push_back(r);
               end
               if (cfg_two_stop) begin
                  m_bits.push_back(1'b1); m_dur.push_back(r);
               end
               m_bits.push_back(1'b1); m_dur.push_back(s);
               m_state = 1; m_seen = 0; m_cnt = 0;
            end
            1: begin
               if (!cts) m_seen = 1;
               if (os_tick) begin
                  m_cnt++;
                  if (m_cnt == m_dur[0]) begin
                     void'(m_bits.pop_front()); void'(m_dur.pop_front());
                     m_cnt = 0;
                     if (m_bits.size() == 0) begin
                        if (m_seen && !cfg_flow_ctl) begin m_state = 2; m_lost = 1; end
                        else m_state = 0;
                     end
                  end
               end
            end
            default: if (restart && cts) begin m_state = 0; m_lost = 0; end
         endcase
      end
   end

   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         bit e_txd, e_rdy;
         e_txd = (m_state == 1) ? m_bits[0] : 1'b1;
         e_rdy = (m_state == 0) && cts;
         chk(txd === e_txd, "R2 txd", txd, e_txd);
         chk(tx_ready === e_rdy, "R8 tx_ready", tx_ready, e_rdy);
         chk(cts_lost === m_lost, "R10 cts_lost", cts_lost, m_lost);
         chk(irq === (m_lost && !cfg_irq_mask), "R9 irq", irq, m_lost && !cfg_irq_mask);
         chk(cfg_err === illegal(cfg_os_mode, cfg_frac), "R6 cfg_err", cfg_err,
             illegal(cfg_os_mode, cfg_frac));
      end
   end

   task automatic send(input logic [7:0] d);
      @(negedge clk);
      tx_data = d; tx_valid = 1'b1;
      #2;
      while (!tx_ready) begin @(negedge clk); #2; end
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 1;
      #2;
      while (!tx_ready) begin @(negedge clk); #2; n++; end
   endtask

   task automatic frame_len(input int mode, input int frac, input bit two, input string tag);
      int n, exp;
      @(negedge clk);
      cfg_os_mode = 2'(mode); cfg_frac = 4'(frac); cfg_two_stop = two;
      send(8'h5A ^ 8'(frac));
      wait_idle(n);
      exp = 9 * rate_of(mode) + (two ? rate_of(mode) : 0) + stop_of(mode, frac);
      chk(n - 1 == exp, tag, n - 1, exp);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      #2;
      chk(txd === 1'b1 && cts_lost === 1'b0 && irq === 1'b0, "R1 reset outputs", txd, 1);
      chk(tx_ready === 1'b1, "R1 reset ready", tx_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // full and shortened stop bits at each rate
      frame_len(1, 15, 0, "R3 16x code 15");
      frame_len(1, 8, 0, "R3 16x code 8");
      frame_len(1, 11, 0, "R3 16x code 11");
      frame_len(2, 0, 0, "R4 32x code 0");
      frame_len(2, 15, 0, "R4 32x code 15");
      frame_len(2, 6, 0, "R4 32x code 6");
      frame_len(0, 12, 0, "R5 8x code 12");
      frame_len(0, 13, 0, "R5 8x code 13");
      frame_len(0, 15, 0, "R5 8x code 15");
      frame_len(1, 3, 0, "R6 16x illegal code");
      frame_len(0, 9, 0, "R6 8x illegal code");
      frame_len(3, 12, 0, "R6 reserved mode");
      frame_len(1, 9, 1, "R7 16x two stop");
      frame_len(2, 2, 1, "R7 32x two stop");

      // R12-style pacing: random oversample enable, back-to-back bytes
      cfg_os_mode = 2'd0; cfg_frac = 4'hD; cfg_two_stop = 1'b0;
      rand_tick = 1'b1;
      for (int k = 0; k < 6; k++) send(8'(k * 37 + 1));
      wait_idle(n);
      rand_tick = 1'b0;

      // R8 CTS dropped mid character, pending byte held
      cfg_os_mode = 2'd1; cfg_frac = 4'hA;
      send(8'hC3);
      repeat (30) @(negedge clk);
      cts = 1'b0;
      repeat (4) @(negedge clk);
      cts = 1'b1;
      tx_data = 8'h81; tx_valid = 1'b1;
      repeat (200) @(negedge clk);
      #2;
      chk(cts_lost === 1'b1, "R8 flag after char", cts_lost, 1);
      chk(tx_ready === 1'b0 && txd === 1'b1, "R8 halted line", tx_ready, 0);
      chk(irq === 1'b1, "R9 irq unmasked", irq, 1);
      @(negedge clk); cfg_irq_mask = 1'b1; #2;
      chk(irq === 1'b0, "R9 irq masked", irq, 0);
      @(negedge clk); cfg_irq_mask = 1'b0;
      cts = 1'b0; restart = 1'b1;
      @(negedge clk); restart = 1'b0; #2;
      chk(cts_lost === 1'b1, "R10 restart without cts", cts_lost, 1);
      cts = 1'b1;
      repeat (3) @(negedge clk); #2;
      chk(cts_lost === 1'b1 && tx_ready === 1'b0, "R10 cts alone no resume", cts_lost, 1);
      restart = 1'b1;
      @(negedge clk); restart = 1'b0; #2;
      chk(cts_lost === 1'b0 && tx_ready === 1'b1, "R10 resumed", cts_lost, 0);
      @(negedge clk); tx_valid = 1'b0; #2;
      chk(txd === 1'b0, "R8 held byte sent", txd, 0);
      wait_idle(n);

      // R11 flow control pause
      cfg_flow_ctl = 1'b1;
      send(8'h3C);
      repeat (40) @(negedge clk);
      cts = 1'b0;
      repeat (200) @(negedge clk); #2;
      chk(cts_lost === 1'b0, "R11 no flag", cts_lost, 0);
      chk(tx_ready === 1'b0, "R11 paused", tx_ready, 0);
      @(negedge clk); cts = 1'b1; #2;
      chk(tx_ready === 1'b1, "R11 resumes with cts", tx_ready, 1);
      cfg_flow_ctl = 1'b0;
      repeat (4) @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule